// File: doc/BRIEF.md
# Floating-Point Compare Flag Generator

This block compares two IEEE-754 values held in 64-bit operand buses and produces a 4-bit condition flag set in N, Z, C, V form. It works in single or double precision. It can also compare the first operand against positive zero instead of against the second operand. An unordered result, where a NaN is involved, gets a flag pattern of its own.

A conditional mode lets the compare depend on flags computed earlier. A 4-bit condition code is tested against the current flags supplied on an input. If the condition holds, the normal compare runs. If it fails, an immediate flag value from the request is loaded unchanged and no compare takes place.

Requests are accepted on `in_valid`. The result is registered and appears one clock later, together with a one-cycle `out_valid` pulse. A request with an unsupported format code raises `fmt_err` and leaves the flags as they were.

Top module: `fcmp_flag_gen`

## Requirements
- R1: Flags are packed as N in bit 3, Z in bit 2, C in bit 1 and V in bit 0. An ordered compare gives 4'b1000 when A < B, 4'b0110 when A == B and 4'b0010 when A > B. V is never set for an ordered result.
- R2: A NaN is an operand whose exponent field is all ones and whose fraction is nonzero. If either operand is a NaN, the flags become 4'b0011. Infinities are ordered values.
- R3: With `fmt` = 0 (single), only bits 31:0 of each operand are used (sign 31, exponent 30:23, fraction 22:0), and bits 63:32 have no effect. With `fmt` = 1 (double), the whole 64 bits are used (sign 63, exponent 62:52, fraction 51:0).
- R4: Positive and negative zero compare equal. Negative values are ordered by sign-magnitude rules, so a larger magnitude is the smaller value.
- R5: When `vs_zero` = 1, operand B is replaced by +0.0 of the selected precision. `op_b` then has no effect, and only `op_a` is tested for NaN.
- R6: When `cond_mode` = 1, the condition code is tested against `cur_flags` (same bit layout as R1). The codes, in pairs where the odd code is the inverse of the even one, are:
  - 0/1: Z
  - 2/3: C
  - 4/5: N
  - 6/7: V
  - 8/9: C and not Z
  - 10/11: N equal to V
  - 12/13: not Z and N equal to V

  When the condition holds, the normal compare result is produced.
- R7: In conditional mode, a failing condition loads `imm_flags` into the flags exactly, whatever the operands are.
- R8: Condition codes 14 and 15 always hold.
- R9: `fmt` values 2 and 3 are invalid. A request with an invalid `fmt` sets `fmt_err` in the result cycle and leaves `flags_out` unchanged.
- R10: A request is sampled at a rising edge while `in_valid` = 1. Its flags, and a one-cycle `out_valid` pulse, are visible after that same edge. Without a request, `flags_out` holds its value and `out_valid` stays 0.
- R11: While `rst_n` is low at a rising edge, `flags_out` becomes 4'b0000 and `out_valid` and `fmt_err` become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| fmt | input | 2 | 0 single, 1 double, 2 and 3 invalid |
| vs_zero | input | 1 | Compare op_a against +0.0 |
| cond_mode | input | 1 | Enable conditional compare |
| cond_code | input | 4 | Condition tested in conditional mode |
| imm_flags | input | 4 | Flags loaded when the condition fails |
| cur_flags | input | 4 | Current flags the condition is tested on |
| flags_out | output | 4 | Registered N,Z,C,V result |
| out_valid | output | 1 | One-cycle pulse with each result |
| fmt_err | output | 1 | Set for a request with an invalid fmt |

## Verification
The hardest case to reach is a conditional request whose condition fails while its operands would themselves give a telling compare result. Only then does a loaded immediate differ visibly from a compare that ran anyway. The stimulus table therefore pairs each failing condition with a NaN or ordered operand pair and an immediate value that no compare can produce, such as 4'b0101 or 4'b1111. Ignored upper halves in single precision are covered the same way: the garbage placed there would make a NaN if it were read.

// File: rtl/fcmp_pkg.sv
// Shared layout constants and types for the compare flag generator.
// Assumes IEEE-754 binary32 and binary64 field layouts.
package fcmp_pkg;

    localparam int OPND_W   = 64;
    localparam int SP_W     = 32;
    localparam int SP_EXP_W = 8;
    localparam int SP_MAN_W = 23;
    localparam int DP_EXP_W = 11;
    localparam int DP_MAN_W = 52;
    localparam int MAG_W    = OPND_W - 1;
    localparam int FLAG_W   = 4;

    // Bit positions inside a flag nibble
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_C = 1;
    localparam int FLG_V = 0;

    // Format codes
    localparam logic [1:0] FMT_SP = 2'd0;
    localparam logic [1:0] FMT_DP = 2'd1;

    // Fixed flag patterns
    localparam logic [FLAG_W-1:0] FLAGS_LT    = 4'b1000;
    localparam logic [FLAG_W-1:0] FLAGS_EQ    = 4'b0110;
    localparam logic [FLAG_W-1:0] FLAGS_GT    = 4'b0010;
    localparam logic [FLAG_W-1:0] FLAGS_UNORD = 4'b0011;

    // Condition groups, selected by the upper three bits of the code
    typedef enum logic [2:0] {
        GRP_ZERO  = 3'd0,
        GRP_CARRY = 3'd1,
        GRP_NEG   = 3'd2,
        GRP_OVF   = 3'd3,
        GRP_ABOVE = 3'd4,
        GRP_SGE   = 3'd5,
        GRP_SGT   = 3'd6,
        GRP_ANY   = 3'd7
    } cond_grp_e;

    // Operand reduced to sign, magnitude and class
    typedef struct packed {
        logic             sign;
        logic [MAG_W-1:0] mag;
        logic             nan;
    } fp_view_t;

endpackage

// File: rtl/fcmp_unpack.sv
// Operand unpacker: reduces one 64-bit operand to a sign, a
// zero-extended magnitude and a NaN flag for the selected precision.
// Assumes single precision lives in the low 32 bits of the bus.
// force_zero replaces the operand with +0.0.
module fcmp_unpack
    import fcmp_pkg::*;
(
    input  logic [OPND_W-1:0] opnd,
    input  logic              is_dbl,
    input  logic              force_zero,
    output fp_view_t          view
);

    localparam int SP_EXP_LSB = SP_MAN_W;
    localparam int DP_EXP_LSB = DP_MAN_W;

    logic [SP_EXP_W-1:0] sp_exp;
    logic [SP_MAN_W-1:0] sp_man;
    logic [DP_EXP_W-1:0] dp_exp;
    logic [DP_MAN_W-1:0] dp_man;
    logic                sp_nan;
    logic                dp_nan;

    // Split both precisions' fields out of the bus
    always_comb begin
        sp_exp = opnd[SP_EXP_LSB +: SP_EXP_W];
        sp_man = opnd[SP_MAN_W-1:0];
        dp_exp = opnd[DP_EXP_LSB +: DP_EXP_W];
        dp_man = opnd[DP_MAN_W-1:0];
        sp_nan = (&sp_exp) && (|sp_man);
        dp_nan = (&dp_exp) && (|dp_man);
    end

    // Choose the precision, or substitute positive zero
    always_comb begin
        if (force_zero) begin
            view.sign = 1'b0;
            view.mag  = '0;
            view.nan  = 1'b0;
        end else if (is_dbl) begin
            view.sign = opnd[OPND_W-1];
            view.mag  = opnd[MAG_W-1:0];
            view.nan  = dp_nan;
        end else begin
            view.sign = opnd[SP_W-1];
            view.mag  = {{(MAG_W-SP_W+1){1'b0}}, opnd[SP_W-2:0]};
            view.nan  = sp_nan;
        end
    end

endmodule

// File: rtl/fcmp_order.sv
// Sign-magnitude ordering of two unpacked operands.
// Assumes neither operand is a NaN when the result is used.
// Signed zeros are treated as equal.
module fcmp_order
    import fcmp_pkg::*;
(
    input  fp_view_t a,
    input  fp_view_t b,
    output logic     is_lt,
    output logic     is_eq,
    output logic     is_gt
);

    logic both_zero;
    logic mag_lt;
    logic mag_gt;

    // Magnitude relations and the signed-zero case
    always_comb begin
        both_zero = (a.mag == '0) && (b.mag == '0);
        mag_lt    = a.mag < b.mag;
        mag_gt    = a.mag > b.mag;
    end

    // Combine signs with magnitudes into the three-way result
    always_comb begin
        is_eq = both_zero || ((a.sign == b.sign) && (a.mag == b.mag));
        is_lt = !is_eq && ((a.sign && !b.sign) ||
                           (!a.sign && !b.sign && mag_lt) ||
                           (a.sign && b.sign && mag_gt));
        is_gt = !is_eq && !is_lt;
    end

endmodule

// File: rtl/fcmp_cond.sv
// Condition evaluator: tests a 4-bit code against an N,Z,C,V nibble.
// The upper three bits pick a group. The low bit inverts the result,
// except for the last group, which always holds.
module fcmp_cond
    import fcmp_pkg::*;
(
    input  logic [3:0]        code,
    input  logic [FLAG_W-1:0] flags,
    output logic              pass
);

    cond_grp_e grp;
    logic      base;
    logic      n_eq_v;

    // Evaluate the group's base predicate
    always_comb begin
        grp    = cond_grp_e'(code[3:1]);
        n_eq_v = flags[FLG_N] == flags[FLG_V];
        unique case (grp)
            GRP_ZERO:  base = flags[FLG_Z];
            GRP_CARRY: base = flags[FLG_C];
            GRP_NEG:   base = flags[FLG_N];
            GRP_OVF:   base = flags[FLG_V];
            GRP_ABOVE: base = flags[FLG_C] && !flags[FLG_Z];
            GRP_SGE:   base = n_eq_v;
            GRP_SGT:   base = !flags[FLG_Z] && n_eq_v;
            default:   base = 1'b1;
        endcase
    end

    // Apply the inversion bit, except for the always-true group
    always_comb begin
        pass = (grp == GRP_ANY) ? 1'b1 : (base ^ code[0]);
    end

endmodule

// File: rtl/fcmp_flag_gen.sv
// Top of the compare flag generator. It unpacks both operands, orders
// them, folds the result into N,Z,C,V and optionally replaces it with an
// immediate when a condition on the current flags fails. The result is
// registered, one cycle of latency. Invalid formats raise fmt_err and
// hold the flags.
module fcmp_flag_gen
    import fcmp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [63:0]       op_a,
    input  logic [63:0]       op_b,
    input  logic [1:0]        fmt,
    input  logic              vs_zero,
    input  logic              cond_mode,
    input  logic [3:0]        cond_code,
    input  logic [3:0]        imm_flags,
    input  logic [3:0]        cur_flags,
    output logic [3:0]        flags_out,
    output logic              out_valid,
    output logic              fmt_err
);

    localparam int N_OPND = 2;

    logic [OPND_W-1:0] opnd   [N_OPND];
    logic              zap    [N_OPND];
    fp_view_t          view   [N_OPND];
    logic              is_dbl;
    logic              fmt_ok;
    logic              lt, eq, gt;
    logic              unord;
    logic              cond_pass;
    logic              run_cmp;
    logic [FLAG_W-1:0] cmp_flags;
    logic [FLAG_W-1:0] nxt_flags;

    // Decode the format and route the operands
    always_comb begin
        fmt_ok  = (fmt == FMT_SP) || (fmt == FMT_DP);
        is_dbl  = (fmt == FMT_DP);
        opnd[0] = op_a;
        opnd[1] = op_b;
        zap[0]  = 1'b0;
        zap[1]  = vs_zero;
    end

    // One unpacker per operand
    for (genvar gi = 0; gi < N_OPND; gi++) begin : g_unpack
        fcmp_unpack u_unpack (
            .opnd       (opnd[gi]),
            .is_dbl     (is_dbl),
            .force_zero (zap[gi]),
            .view       (view[gi])
        );
    end

    fcmp_order u_order (
        .a     (view[0]),
        .b     (view[1]),
        .is_lt (lt),
        .is_eq (eq),
        .is_gt (gt)
    );

    fcmp_cond u_cond (
        .code  (cond_code),
        .flags (cur_flags),
        .pass  (cond_pass)
    );

    // Fold the ordering into a flag nibble, unordered first
    always_comb begin
        unord = view[0].nan || view[1].nan;
        if (unord)      cmp_flags = FLAGS_UNORD;
        else if (lt)    cmp_flags = FLAGS_LT;
        else if (eq)    cmp_flags = FLAGS_EQ;
        else if (gt)    cmp_flags = FLAGS_GT;
        else            cmp_flags = FLAGS_UNORD;
    end

    // Pick the compare result or the immediate
    always_comb begin
        run_cmp   = !cond_mode || cond_pass;
        nxt_flags = run_cmp ? cmp_flags : imm_flags;
    end

    // Result register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_out <= '0;
            out_valid <= 1'b0;
            fmt_err   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            fmt_err   <= in_valid && !fmt_ok;
            if (in_valid && fmt_ok) begin
                flags_out <= nxt_flags;
            end
        end
    end

endmodule

// File: rtl/fcmp_flag_gen_chk.sv
// Checker for the compare flag generator, bound to every instance.
// It observes ports only.
module fcmp_flag_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic [63:0] op_a,
    input logic [1:0]  fmt,
    input logic        cond_mode,
    input logic [3:0]  cond_code,
    input logic [3:0]  imm_flags,
    input logic [3:0]  cur_flags,
    input logic [3:0]  flags_out,
    input logic        out_valid,
    input logic        fmt_err
);

    AST_ORDERED_PATTERN: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !fmt[1] && !cond_mode |=>
        (flags_out == 4'b1000) || (flags_out == 4'b0110) ||
        (flags_out == 4'b0010) || (flags_out == 4'b0011)); // R1

    AST_DP_NAN_UNORD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && fmt == 2'd1 && !cond_mode &&
        (&op_a[62:52]) && (|op_a[51:0]) |=> flags_out == 4'b0011); // R2

    AST_IMM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !fmt[1] && cond_mode && cond_code == 4'd0 && !cur_flags[2]
        |=> flags_out == $past(imm_flags)); // R7

    AST_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !fmt[1] && cond_mode && cond_code[3:1] == 3'b111 |=>
        (flags_out == 4'b1000) || (flags_out == 4'b0110) ||
        (flags_out == 4'b0010) || (flags_out == 4'b0011)); // R8

    AST_BAD_FMT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && fmt[1] |=> fmt_err && $stable(flags_out)); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !fmt_err && $stable(flags_out)); // R10

    AST_RESULT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10

endmodule

bind fcmp_flag_gen fcmp_flag_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_a      (op_a),
    .fmt       (fmt),
    .cond_mode (cond_mode),
    .cond_code (cond_code),
    .imm_flags (imm_flags),
    .cur_flags (cur_flags),
    .flags_out (flags_out),
    .out_valid (out_valid),
    .fmt_err   (fmt_err)
);

// File: tb/test_fcmp_flag_gen.sv
`timescale 1ns/1ps
// Bench for the compare flag generator: table-driven vectors, then
// directed checks for reset, invalid format and latency.
module test_fcmp_flag_gen;

    typedef struct packed {
        logic [7:0]  req;
        logic        cmode;
        logic [3:0]  ccode;
        logic [3:0]  cur;
        logic [3:0]  imm;
        logic [1:0]  fmt;
        logic        vz;
        logic [63:0] a;
        logic [63:0] b;
        logic [3:0]  exp;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VECS [NV] = '{
        // R1 single ordered
        '{8'd1, 1'b0, 4'd0, 4'h0, 4'h0, 2'd0, 1'b0, 64'h3F800000, 64'h40000000, 4'b1000},
        '{8'd1, 1'b0, 4'd0, 4'h0, 4'h0, 2'd0, 1'b0, 64'h40000000, 64'h3F800000, 4'b0010},
        '{8'd1, 1'b0, 4'd0, 4'h0, 4'h0, 2'd0, 1'b0, 64'h3F800000, 64'h3F800000, 4'b0110},
        // R4 negative ordering
        '{8'd4, 1'b0, 4'd0, 4'h0, 4'h0, 2'd0, 1'b0, 64'hBF800000, 64'h3F800000, 4'b1000},
        '{8'd4, 1'b0, 4'd0, 4'h0, 4'h0, 2'd0, 1'b0, 64'hBF800000, 64'hC0000000, 4'b0010},
        // R2 NaN and infinity
        '{8'd2, 1'b0, 4'd0, 4'h0, 4'h0, 2'd0, 1'b0, 64'h7FC00000, 64'h3F800000, 4'b0011},
        '{8'd2, 1'b0, 4'd0, 4'h0, 4'h0, 2'd0, 1'b0, 64'h3F800000, 64'h7F800001, 4'b0011},
        '{8'd2, 1'b0, 4'd0, 4'h0, 4'h0, 2'd0, 1'b0, 64'h7F800000, 64'h3F800000, 4'b0010},
        // R3 upper halves ignored in single precision
        '{8'd3, 1'b0, 4'd0, 4'h0, 4'h0, 2'd0, 1'b0, 64'hFFFFFFFF_3F800000, 64'h12345678_40000000, 4'b1000},
        // R4 signed zeros
        '{8'd4, 1'b0, 4'd0, 4'h0, 4'h0, 2'd0, 1'b0, 64'h80000000, 64'h00000000, 4'b0110},
        // R3 double precision
        '{8'd3, 1'b0, 4'd0, 4'h0, 4'h0, 2'd1, 1'b0, 64'h3FF0000000000000, 64'h4000000000000000, 4'b1000},
        '{8'd4, 1'b0, 4'd0, 4'h0, 4'h0, 2'd1, 1'b0, 64'hC000000000000000, 64'h3FF0000000000000, 4'b1000},
        '{8'd2, 1'b0, 4'd0, 4'h0, 4'h0, 2'd1, 1'b0, 64'h7FF8000000000000, 64'h3FF0000000000000, 4'b0011},
        '{8'd4, 1'b0, 4'd0, 4'h0, 4'h0, 2'd1, 1'b0, 64'hFFF0000000000000, 64'hC000000000000000, 4'b1000},
        '{8'd4, 1'b0, 4'd0, 4'h0, 4'h0, 2'd1, 1'b0, 64'h8000000000000000, 64'h0000000000000000, 4'b0110},
        // R5 compare with zero
        '{8'd5, 1'b0, 4'd0, 4'h0, 4'h0, 2'd1, 1'b1, 64'h3FF0000000000000, 64'h7FF8000000000000, 4'b0010},
        '{8'd5, 1'b0, 4'd0, 4'h0, 4'h0, 2'd1, 1'b1, 64'hC000000000000000, 64'hFFF0000000000000, 4'b1000},
        '{8'd5, 1'b0, 4'd0, 4'h0, 4'h0, 2'd0, 1'b1, 64'h7FC00000, 64'h00000000, 4'b0011},
        '{8'd5, 1'b0, 4'd0, 4'h0, 4'h0, 2'd1, 1'b1, 64'h8000000000000000, 64'h4000000000000000, 4'b0110},
        // R6 conditions that hold
        '{8'd6, 1'b1, 4'd0, 4'b0100, 4'b0101, 2'd0, 1'b0, 64'h3F800000, 64'h40000000, 4'b1000},
        '{8'd6, 1'b1, 4'd10, 4'b1001, 4'b1111, 2'd1, 1'b0, 64'h4000000000000000, 64'h3FF0000000000000, 4'b0010},
        '{8'd6, 1'b1, 4'd8, 4'b0010, 4'b1111, 2'd0, 1'b0, 64'h40000000, 64'h40000000, 4'b0110},
        // R7 failing conditions load the immediate
        '{8'd7, 1'b1, 4'd0, 4'b0000, 4'b0101, 2'd0, 1'b0, 64'h7FC00000, 64'h3F800000, 4'b0101},
        '{8'd7, 1'b1, 4'd10, 4'b1000, 4'b1100, 2'd1, 1'b0, 64'h3FF0000000000000, 64'h3FF0000000000000, 4'b1100},
        '{8'd7, 1'b1, 4'd9, 4'b0010, 4'b0001, 2'd0, 1'b0, 64'h40000000, 64'h3F800000, 4'b0001},
        '{8'd7, 1'b1, 4'd12, 4'b0100, 4'b1010, 2'd0, 1'b0, 64'h40000000, 64'h3F800000, 4'b1010},
        '{8'd7, 1'b1, 4'd3, 4'b0010, 4'b0111, 2'd1, 1'b0, 64'h7FF8000000000000, 64'h0, 4'b0111},
        // R8 always-true codes
        '{8'd8, 1'b1, 4'd14, 4'b0000, 4'b1111, 2'd0, 1'b0, 64'h7FC00000, 64'h3F800000, 4'b0011},
        '{8'd8, 1'b1, 4'd15, 4'b0000, 4'b1111, 2'd1, 1'b0, 64'h3FF0000000000000, 64'h3FF0000000000000, 4'b0110}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [1:0]  fmt = '0;
    logic        vs_zero = 1'b0;
    logic        cond_mode = 1'b0;
    logic [3:0]  cond_code = '0;
    logic [3:0]  imm_flags = '0;
    logic [3:0]  cur_flags = '0;
    logic [3:0]  flags_out;
    logic        out_valid;
    logic        fmt_err;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fcmp_flag_gen i_fcmp_flag_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_a      (op_a),
        .op_b      (op_b),
        .fmt       (fmt),
        .vs_zero   (vs_zero),
        .cond_mode (cond_mode),
        .cond_code (cond_code),
        .imm_flags (imm_flags),
        .cur_flags (cur_flags),
        .flags_out (flags_out),
        .out_valid (out_valid),
        .fmt_err   (fmt_err)
    );

    task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        in_valid  = 1'b1;
        cond_mode = v.cmode;
        cond_code = v.ccode;
        cur_flags = v.cur;
        imm_flags = v.imm;
        fmt       = v.fmt;
        vs_zero   = v.vz;
        op_a      = v.a;
        op_b      = v.b;
        @(negedge clk);
        in_valid  = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL R10: watchdog expired, got no finish expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        vec_t v;
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 flags after reset", flags_out, 4'b0000);
        check("R11 valid after reset", {3'b0, out_valid}, 4'b0000);
        check("R11 err after reset", {3'b0, fmt_err}, 4'b0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            check($sformatf("R%0d vector %0d flags", VECS[i].req, i), flags_out, VECS[i].exp);
            check($sformatf("R10 vector %0d valid", i), {3'b0, out_valid}, 4'b0001);
        end

        // R9 invalid format holds the previous flags
        drive(VECS[0]);
        check("R1 before bad fmt", flags_out, 4'b1000);
        v = VECS[1];
        v.fmt = 2'd2;
        drive(v);
        check("R9 flags held", flags_out, 4'b1000);
        check("R9 error raised", {3'b0, fmt_err}, 4'b0001);
        v.fmt = 2'd3;
        drive(v);
        check("R9 fmt 3 flags held", flags_out, 4'b1000);
        check("R9 fmt 3 error", {3'b0, fmt_err}, 4'b0001);
        drive(VECS[1]);
        check("R9 error clears", {3'b0, fmt_err}, 4'b0000);
        check("R9 good request after error", flags_out, 4'b0010);

        // R10 latency: nothing changes before the sampling edge
        @(negedge clk);
        check("R10 idle valid low", {3'b0, out_valid}, 4'b0000);
        check("R10 idle flags held", flags_out, 4'b0010);
        in_valid  = 1'b1;
        cond_mode = 1'b0;
        vs_zero   = 1'b0;
        fmt       = 2'd0;
        op_a      = 64'h3F800000;
        op_b      = 64'h3F800000;
        #1;
        check("R10 no early update", flags_out, 4'b0010);
        @(negedge clk);
        in_valid = 1'b0;
        check("R10 updated after edge", flags_out, 4'b0110);
        @(negedge clk);
        check("R10 pulse ends", {3'b0, out_valid}, 4'b0000);
        check("R10 flags hold when idle", flags_out, 4'b0110);

        // R11 reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R11 flags cleared", flags_out, 4'b0000);
        rst_n = 1'b1;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule